// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner takes a wide vector of level-high interrupt sources and partitions it into groups of eight. Each group has its own enable bits and drives a single registered output line toward a parent interrupt controller. A group's line is high whenever at least one of its enabled sources is high, and it drops again as soon as those sources go low. The line is not latched.

Software reaches the block over a small memory-mapped register bus. Four groups share one 32-bit register bank. Enable bits change only through a write-one-to-set register and a write-one-to-clear register, so one source can be enabled or disabled without a read-modify-write. A read-only status register shows the raw, unmasked level of every source in the bank. This lets software decide which source in a group caused an interrupt by combining the status with its own copy of the enables. The group count is a parameter, and the number of banks follows from it.

Top module: `irq_combiner`

## Requirements
- R1: While `rst` is high at a clock edge, every enable bit, every `grp_irq` line and `bus_rdata` are cleared to zero.
- R2: Group g uses bits [8*(g%4)+7 : 8*(g%4)] of bank k = g/4. Source bit i of group g is `src_in[8*g+i]`. The bank occupies byte offsets 0x10*k to 0x10*k+0xF, selected by `bus_addr[ADDR_W-1:4]`.
- R3: A write to bank offset 0x0 enables every source whose write-data bit is 1. Bits written as 0 leave their enable unchanged.
- R4: A write to bank offset 0x4 disables every source whose write-data bit is 1. Bits written as 0 leave their enable unchanged.
- R5: A read of bank offset 0xC returns the raw source levels of that bank, whatever the enables are. A write to 0xC changes no enable.
- R6: A read of bank offset 0x0 or of offset 0x4 returns the bank's current enable mask.
- R7: Reads of offset 0x8 or of any bank index at or above the bank count return zero. Writes there change no enable.
- R8: `grp_irq[g]` equals the OR over the group's eight bits of (source AND enable), sampled at the previous clock edge. It follows the source level and does not latch.
- R9: `bus_rdata` holds the read result in the cycle after the edge at which `bus_rd` was sampled high. In every other cycle it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address: bank in the upper bits, register offset in bits 3:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 8*NUM_GROUPS | Level-high interrupt sources, already synchronised |
| grp_irq | output | NUM_GROUPS | Registered combined line per group |

## Verification
The assertions assume that `src_in` is synchronous to `clk` and only changes between edges. They also assume that `bus_rd` and `bus_wr` are never high in the same cycle, so a read and a write never target the bank together. The bench changes sources and strobes only at the falling edge, and it issues exactly one bus operation at a time. Its random sequence mixes set, clear, status and unmapped accesses across both banks and beyond them, together with fresh source patterns.

// File: rtl/combiner_pkg.sv
package combiner_pkg;
  localparam int SRC_PER_GROUP   = 8;
  localparam int GROUPS_PER_BANK = 4;
  localparam int BANK_W          = SRC_PER_GROUP * GROUPS_PER_BANK;
  localparam logic [3:0] OFF_EN_SET = 4'h0;
  localparam logic [3:0] OFF_EN_CLR = 4'h4;
  localparam logic [3:0] OFF_RAW    = 4'hC;

  function automatic logic [BANK_W-1:0] lane_mask(input int groups);
    logic [BANK_W-1:0] m;
    m = '0;
    for (int i = 0; i < BANK_W; i++)
      if (i < groups * SRC_PER_GROUP) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/comb_enable_bank.sv
module comb_enable_bank
  import combiner_pkg::*;
#(
  parameter logic [BANK_W-1:0] VALID_MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)
      en_q <= '0;
    else if (set_we)
      en_q <= en_q | (wdata & VALID_MASK);
    else if (clr_we)
      en_q <= en_q & ~wdata;
  end
endmodule

// File: rtl/comb_group_or.sv
module comb_group_or
  import combiner_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SRC_PER_GROUP-1:0] src,
  input  logic [SRC_PER_GROUP-1:0] en,
  output logic                     irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(src & en);
  end
endmodule

// File: rtl/comb_read_mux.sv
module comb_read_mux
  import combiner_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BSEL_W    = 4
) (
  input  logic [BSEL_W-1:0]           bank_sel,
  input  logic [3:0]                  offset,
  input  logic [NUM_BANKS*BANK_W-1:0] en_flat,
  input  logic [NUM_BANKS*BANK_W-1:0] raw_flat,
  output logic [BANK_W-1:0]           rd_val
);
  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (bank_sel == BSEL_W'(k)) begin
        if (offset == OFF_EN_SET || offset == OFF_EN_CLR)
          rd_val = en_flat[k*BANK_W +: BANK_W];
        else if (offset == OFF_RAW)
          rd_val = raw_flat[k*BANK_W +: BANK_W];
      end
    end
  end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import combiner_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int ADDR_W     = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bus_wr,
  input  logic                              bus_rd,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [BANK_W-1:0]                 bus_wdata,
  output logic [BANK_W-1:0]                 bus_rdata,
  input  logic [NUM_GROUPS*SRC_PER_GROUP-1:0] src_in,
  output logic [NUM_GROUPS-1:0]             grp_irq
);
  localparam int NUM_BANKS = (NUM_GROUPS + GROUPS_PER_BANK - 1) / GROUPS_PER_BANK;
  localparam int FLAT_W    = NUM_BANKS * BANK_W;
  localparam int BSEL_W    = ADDR_W - 4;

  logic [BSEL_W-1:0] bank_sel;
  logic [3:0]        offset;
  logic [FLAT_W-1:0] en_flat;
  logic [FLAT_W-1:0] raw_flat;
  logic [BANK_W-1:0] rd_val;

  assign bank_sel = bus_addr[ADDR_W-1:4];
  assign offset   = bus_addr[3:0];
  assign raw_flat = FLAT_W'(src_in);

  // one enable register per bank; lanes past the last group stay zero
  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    localparam int LANES = (NUM_GROUPS - k*GROUPS_PER_BANK >= GROUPS_PER_BANK)
                           ? GROUPS_PER_BANK : NUM_GROUPS - k*GROUPS_PER_BANK;
    logic hit;
    assign hit = (bank_sel == BSEL_W'(k));
    comb_enable_bank #(.VALID_MASK(lane_mask(LANES))) u_bank (
      .clk    (clk),
      .rst    (rst),
      .set_we (bus_wr && hit && offset == OFF_EN_SET),
      .clr_we (bus_wr && hit && offset == OFF_EN_CLR),
      .wdata  (bus_wdata),
      .en_q   (en_flat[k*BANK_W +: BANK_W])
    );
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    comb_group_or u_or (
      .clk   (clk),
      .rst   (rst),
      .src   (src_in[g*SRC_PER_GROUP +: SRC_PER_GROUP]),
      .en    (en_flat[g*SRC_PER_GROUP +: SRC_PER_GROUP]),
      .irq_q (grp_irq[g])
    );
  end

  comb_read_mux #(.NUM_BANKS(NUM_BANKS), .BSEL_W(BSEL_W)) u_rmux (
    .bank_sel (bank_sel),
    .offset   (offset),
    .en_flat  (en_flat),
    .raw_flat (raw_flat),
    .rd_val   (rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
  parameter int NUM_GROUPS = 8,
  parameter int ADDR_W     = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_rd,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [31:0]             bus_rdata,
  input logic [NUM_GROUPS*8-1:0] src_in,
  input logic [NUM_GROUPS-1:0]   grp_irq
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (grp_irq == '0 && bus_rdata == '0));

  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);

  // R5
  status_raw_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(12)) |=> bus_rdata[7:0] == $past(src_in[7:0]));

  // R7
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[3:0] == 4'h8) |=> bus_rdata == '0);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    // R8
    quiet_group_chk: assert property (@(posedge clk) disable iff (rst)
      (src_in[g*8 +: 8] == 8'h00) |=> !grp_irq[g]);
    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(grp_irq[g]) |-> $past(|src_in[g*8 +: 8]));
  end
endmodule

bind irq_combiner irq_combiner_chk #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .src_in    (src_in),
  .grp_irq   (grp_irq)
);

// File: tb/irq_combiner_test.sv
module irq_combiner_test;
  localparam int NG = 8;
  localparam int AW = 8;
  localparam int NB = (NG + 3) / 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NG*8-1:0] src_in = '0;
  logic [NG-1:0]   grp_irq;

  logic [NG*8-1:0] m_en = '0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) uut (.*);

  function automatic logic [NG-1:0] exp_irq(input logic [NG*8-1:0] s, input logic [NG*8-1:0] e);
    logic [NG-1:0] r;
    for (int g = 0; g < NG; g++) r[g] = |(s[g*8 +: 8] & e[g*8 +: 8]);
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    int bk;
    logic [NB*32-1:0] ep, sp;
    bk = int'(a[AW-1:4]);
    ep = (NB*32)'(m_en);
    sp = (NB*32)'(src_in);
    if (bk >= NB) return '0;
    case (a[3:0])
      4'h0, 4'h4: return ep[bk*32 +: 32];
      4'hC:       return sp[bk*32 +: 32];
      default:    return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    int bk;
    logic [NB*32-1:0] ep;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    bk = int'(a[AW-1:4]);
    ep = (NB*32)'(m_en);
    if (bk < NB) begin
      if (a[3:0] == 4'h0) ep[bk*32 +: 32] = ep[bk*32 +: 32] | d;
      else if (a[3:0] == 4'h4) ep[bk*32 +: 32] = ep[bk*32 +: 32] & ~d;
    end
    m_en = ep[NG*8-1:0];
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input string req);
    logic [31:0] e;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    e = exp_read(a);
    @(posedge clk);
    @(negedge clk);
    check(req, 64'(bus_rdata), 64'(e));
    bus_rd = 1'b0;
  endtask

  // one idle cycle, then irq reflects sources and enables of that edge
  task automatic settle(input string req);
    @(posedge clk);
    @(negedge clk);
    check(req, 64'(grp_irq), 64'(exp_irq(src_in, m_en)));
    check("R9 idle rdata", 64'(bus_rdata), 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    src_in = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq after reset", 64'(grp_irq), 64'h0);
    check("R1 rdata after reset", 64'(bus_rdata), 64'h0);
    bus_read(8'h00, "R1 bank0 enables");
    bus_read(8'h14, "R1 bank1 enables");
    settle("R1 no irq with all sources high");

    // R3 set: zeros ignored, group 0 enabled
    bus_write(8'h00, 32'h0000_00A5);
    bus_write(8'h00, 32'h0000_0000);
    bus_read(8'h00, "R3 set keeps A5");
    settle("R8 group0 fires");
    // R4 clear one bit, zeros ignored
    bus_write(8'h04, 32'h0000_0001);
    bus_read(8'h04, "R6 read via clear offset");
    check("R4 model mask", 64'(m_en[7:0]), 64'hA4);
    // R2 group 5 lives in bank1 lane1
    bus_write(8'h10, 32'h0000_0100);
    src_in = '0; src_in[5*8] = 1'b1;
    settle("R2 group5 only");
    check("R2 group5 line", 64'(grp_irq), 64'h20);
    // R8 level follow, no latching
    src_in = '0;
    settle("R8 falls with sources");
    // R5 raw status ignores enables; writes to it ignored
    src_in = 64'h1234_5678_9ABC_DEF0;
    bus_write(8'h0C, 32'hFFFF_FFFF);
    bus_read(8'h0C, "R5 raw status bank0");
    bus_read(8'h1C, "R5 raw status bank1");
    bus_read(8'h00, "R5 status write no effect");
    // R7 unmapped
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_read(8'h08, "R7 offset 8 reads zero");
    bus_read(8'h2C, "R7 bank2 reads zero");
    bus_read(8'h10, "R7 writes ignored bank1");
    bus_read(8'h00, "R7 writes ignored bank0");
    settle("R8 after unmapped writes");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a;
      int op;
      op = int'($urandom_range(0, 3));
      a = AW'({$urandom_range(0, 2), 4'(4 * $urandom_range(0, 3))});
      if ($urandom_range(0, 3) == 0) src_in = {$urandom, $urandom};
      if (op == 0) bus_write({a[AW-1:4], 4'h0}, $urandom);
      else if (op == 1) bus_write({a[AW-1:4], 4'h4}, $urandom);
      else if (op == 2) bus_write(a, $urandom);
      else bus_read(a, "R6 R5 R7 random read");
      settle("R8 random irq");
    end

    // R1 reset mid-run clears enables
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    m_en = '0;
    check("R1 irq after late reset", 64'(grp_irq), 64'h0);
    bus_read(8'h10, "R1 enables after late reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule